// File: doc/BRIEF.md
# Mains-Synchronised BCD Calendar Timekeeper

This block keeps wall-clock time and a calendar. It takes its time base from a clean, single-cycle pulse that marks every cycle of the 50 Hz or 60 Hz mains supply. The pulse has already been digitised and synchronised to `clk`. A counter of mains cycles makes the seconds. From the seconds the block carries into minutes, hours, date, month, year and day-of-week. Every field is held in packed BCD.

A simple register port lets a host set and read the time. The same port holds two daylight-saving rules, one for spring and one for autumn. With the enable bit set, the block jumps the clock ahead one hour when it enters the programmed spring hour on the programmed month and date. When it enters the autumn hour on its date, it sets the clock back one hour. The block then stays locked so that the repeated hour does not move the clock back a second time. A one-cycle `sec_tick` marks each new second, for use by comparison logic downstream.

Top module: `mains_bcd_calendar`

## Requirements
- R1: After reset the time registers read seconds 00, minutes 00, hours 00, date 01, month 01, year 00, day-of-week 00 and sub-second 00. Every daylight-saving register reads 00, so the adjustments are disabled.
- R2: When `mode_60hz` is 0, 50 `line_pulse` cycles make one second. When it is 1, 60 cycles make one second. The sub-second register (address 07h) reads the count of cycles already taken, in BCD (00–49 or 00–59). `sec_tick` is high for exactly one cycle, the cycle after the pulse that completes the second.
- R3: Seconds (address 00h) and minutes (01h) count 00–59 in BCD. When seconds wrap, minutes advance. When minutes wrap, hours advance.
- R4: Hours (02h) count 00–23. On the wrap from 23 to 00, date advances and day-of-week (06h) advances 0–6, wrapping from 6 to 0.
- R5: Date (03h) wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the other months. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. On the wrap, month (04h) advances.
- R6: Month wraps from 12 to 01 and advances the year (05h). The year wraps from 99 to 00.
- R7: A write with `reg_we` high stores `reg_wdata` at `reg_addr` at the next clock edge. The writable addresses are the time fields 00h–06h and the daylight-saving registers 15h–1Ch. `reg_rdata` shows the addressed register in the same cycle. Other addresses read 00.
- R8: A write to any of addresses 00h–07h clears the mains-cycle counter, so the next full second starts at that point. The data written to 07h is discarded. If the write and a `line_pulse` fall in the same cycle, the write wins and that pulse is not counted.
- R9: The spring rule uses month at 15h (bits 4:0), day at 16h, date at 17h and hour at 18h. Bit 7 of 15h is the daylight-saving enable. When the enable is set and the clock enters the hour in 18h (with minutes and seconds both 00) on the month in 15h and the date in 17h, the hour becomes that value plus one. The programmed hour must be 00–22.
- R10: The autumn rule uses month at 19h, day at 1Ah, date at 1Bh and hour at 1Ch. The hour must be 01–23. When the enable is set and the clock enters the hour in 1Ch on the matching month and date, the hour becomes that value minus one and a lock is set. While the lock is set, the next entry into that same hour is left alone. Entering any other hour clears the lock. If both rules match, the spring rule takes priority.
- R11: With bit 7 of 15h clear, neither rule changes the hour. The day registers 16h and 1Ah are stored and read back but do not take part in any match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_60hz | input | 1 | 1: 60 cycles per second, 0: 50 cycles per second |
| line_pulse | input | 1 | One-cycle pulse per mains cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| sec_tick | output | 1 | One-cycle pulse at every new second |

## Verification
The bench targets the carry chain at its worst points:
- 23:59:59 on the last day of February, both in a leap year and in a common year. A wrong month-length table would show a 29th in a common year or skip the 29th in a leap year.
- New Year's Eve of year 99. A design that got this wrong would not wrap month or year.

It also counts pulses around the 49/59 boundary in both modes. A counter off by one would make `sec_tick` fire one cycle early or late.

For daylight saving, the bench replays the autumn hour by writing minutes and seconds back to 59:59. A design without the lock would step back a second time. The same check is repeated with the enable bit clear, where the hour must not move.

A write colliding with a mains pulse is also checked. A design that counted that pulse would read sub-second 01 instead of 00.

// File: rtl/mains_bcd_calendar.sv
module mains_bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_60hz,
  input  logic       line_pulse,
  input  logic       reg_we,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sec_tick
);

  localparam logic [4:0] DST_BASE = 5'h15;
  localparam int         DST_REGS = 8;

  logic [7:0] sec, min, hour, date, mon, year, dow, sub;
  logic [7:0] dst_cfg [DST_REGS];
  logic       rev_lock;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] bdec(input logic [7:0] v);
    return (v[3:0] == 4'd0) ? {v[7:4] - 4'd1, 4'd9} : v - 8'd1;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    case (m)
      8'h02:                      return (r == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic       wr_time, wr_cfg, adv;
  logic       roll_s, roll_m, roll_h, roll_d, roll_mo;
  logic [7:0] n_sec, n_min, n_hour, n_date, n_mon, n_year, n_dow, hour_out;
  logic [4:0] cfg_idx;
  logic       dst_en, fwd_hit, rev_hit;

  assign wr_time = reg_we && (reg_addr < 5'd8);
  assign cfg_idx = reg_addr - DST_BASE;
  assign wr_cfg  = reg_we && (reg_addr >= DST_BASE) && (cfg_idx < 5'(DST_REGS));
  assign adv     = line_pulse && !wr_time && (sub >= (mode_60hz ? 8'h59 : 8'h49));

  assign roll_s  = sec == 8'h59;
  assign roll_m  = roll_s && (min == 8'h59);
  assign roll_h  = roll_m && (hour == 8'h23);
  assign roll_d  = roll_h && (date == month_len(mon, year));
  assign roll_mo = roll_d && (mon == 8'h12);

  assign n_sec  = roll_s ? 8'h00 : binc(sec);
  assign n_min  = roll_m ? 8'h00 : roll_s ? binc(min) : min;
  assign n_hour = roll_h ? 8'h00 : roll_m ? binc(hour) : hour;
  assign n_date = roll_d ? 8'h01 : roll_h ? binc(date) : date;
  assign n_mon  = roll_mo ? 8'h01 : roll_d ? binc(mon) : mon;
  assign n_year = !roll_mo ? year : (year == 8'h99) ? 8'h00 : binc(year);
  assign n_dow  = !roll_h ? dow : (dow >= 8'h06) ? 8'h00 : dow + 8'd1;

  assign dst_en  = dst_cfg[0][7];
  assign fwd_hit = dst_en && roll_m && (n_mon == {3'b0, dst_cfg[0][4:0]}) &&
                   (n_date == dst_cfg[2]) && (n_hour == dst_cfg[3]);
  assign rev_hit = dst_en && roll_m && !fwd_hit && (n_mon == dst_cfg[4]) &&
                   (n_date == dst_cfg[6]) && (n_hour == dst_cfg[7]);
  assign hour_out = fwd_hit ? binc(n_hour) : (rev_hit && !rev_lock) ? bdec(n_hour) : n_hour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00; date <= 8'h01;
      mon <= 8'h01; year <= 8'h00; dow <= 8'h00; sub <= 8'h00;
      rev_lock <= 1'b0;
      sec_tick <= 1'b0;
      for (int i = 0; i < DST_REGS; i++) dst_cfg[i] <= 8'h00;
    end else begin
      sec_tick <= adv;
      if (wr_cfg) dst_cfg[cfg_idx[2:0]] <= reg_wdata;
      if (wr_time) begin
        sub <= 8'h00;
        case (reg_addr[2:0])
          3'd0: sec  <= reg_wdata;
          3'd1: min  <= reg_wdata;
          3'd2: hour <= reg_wdata;
          3'd3: date <= reg_wdata;
          3'd4: mon  <= reg_wdata;
          3'd5: year <= reg_wdata;
          3'd6: dow  <= reg_wdata;
          default: ;
        endcase
      end else if (line_pulse) begin
        if (adv) begin
          sub  <= 8'h00;
          sec  <= n_sec;
          min  <= n_min;
          hour <= hour_out;
          date <= n_date;
          mon  <= n_mon;
          year <= n_year;
          dow  <= n_dow;
          if (roll_m) rev_lock <= rev_hit;
        end else begin
          sub <= binc(sub);
        end
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      5'h00: reg_rdata = sec;
      5'h01: reg_rdata = min;
      5'h02: reg_rdata = hour;
      5'h03: reg_rdata = date;
      5'h04: reg_rdata = mon;
      5'h05: reg_rdata = year;
      5'h06: reg_rdata = dow;
      5'h07: reg_rdata = sub;
      default: if (reg_addr >= DST_BASE && cfg_idx < 5'(DST_REGS)) reg_rdata = dst_cfg[cfg_idx[2:0]];
    endcase
  end

  // R2: a second only completes on a counted mains pulse, and the tick lasts one cycle
  p_tick_on_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(line_pulse));
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  p_sub_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sub <= 8'h59);
  // R3: the time fields move only on a second or a host write
  p_time_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !$past(reg_we)) |-> ($stable(sec) && $stable(min) && $stable(hour) && $stable(date)));
  // R8: a time write restarts the cycle count
  p_sub_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr < 5'd8) |=> (sub == 8'h00));
  // R10: the lock is set by an autumn step that left the programmed hour
  p_lock_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_lock) |-> (sec_tick && hour != dst_cfg[7]));
  // R11: no lock arises while the enable was clear
  p_lock_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_lock) |-> $past(dst_cfg[0][7]));

endmodule

// File: tb/test_mains_bcd_calendar.sv
module test_mains_bcd_calendar;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_60hz = 1'b0;
  logic       line_pulse = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = 5'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sec_tick;

  mains_bcd_calendar i_mains_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .mode_60hz(mode_60hz), .line_pulse(line_pulse),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sec_tick(sec_tick)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0, tick_cnt = 0, tick_exp = 0;
  int s, m, h, d, mo, y, w, sub, lock;
  logic [7:0] cfg [8];

  always @(negedge clk) if (rst_n && sec_tick) tick_cnt++;

  function automatic logic [7:0] tobcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int frombcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(input int mm, input int yy);
    if (mm == 2) return (yy % 4 == 0) ? 29 : 28;
    if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_second();
    tick_exp++;
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; w = (w + 1) % 7; d++;
          if (d > days_in(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
        if (cfg[0][7] && mo == frombcd(cfg[0] & 8'h1F) && d == frombcd(cfg[2]) && h == frombcd(cfg[3])) begin
          h++; lock = 0;
        end else if (cfg[0][7] && mo == frombcd(cfg[4]) && d == frombcd(cfg[6]) && h == frombcd(cfg[7])) begin
          if (lock == 0) h--;
          lock = 1;
        end else lock = 0;
      end
    end
  endtask

  task automatic model_write(input logic [4:0] a, input logic [7:0] v);
    case (a)
      5'h00: s  = frombcd(v);
      5'h01: m  = frombcd(v);
      5'h02: h  = frombcd(v);
      5'h03: d  = frombcd(v);
      5'h04: mo = frombcd(v);
      5'h05: y  = frombcd(v);
      5'h06: w  = frombcd(v);
      default: if (a >= 5'h15 && a <= 5'h1C) cfg[a - 5'h15] = v;
    endcase
    if (a < 5'd8) sub = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
    model_write(a, v);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); line_pulse = 1'b1;
    @(negedge clk); line_pulse = 1'b0;
    if (sub == (mode_60hz ? 59 : 49)) begin sub = 0; model_second(); end
    else sub++;
  endtask

  task automatic one_second();
    repeat (mode_60hz ? 60 : 50) pulse();
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    int exp [8];
    exp = '{s, m, h, d, mo, y, w, sub};
    for (int a = 0; a < 8; a++) begin
      rd(5'(a), v);
      chk(req, $sformatf("reg %0h", a), v, tobcd(exp[a]));
    end
    @(negedge clk);
    chk(req, "tick count", tick_cnt, tick_exp);
  endtask

  task automatic set_time(input int yy, input int mm, input int dd, input int hh,
                          input int mi, input int ss, input int ww);
    wr(5'h05, tobcd(yy)); wr(5'h04, tobcd(mm)); wr(5'h03, tobcd(dd));
    wr(5'h02, tobcd(hh)); wr(5'h01, tobcd(mi)); wr(5'h06, tobcd(ww));
    wr(5'h00, tobcd(ss));
  endtask

  logic [7:0] rv;

  initial begin
    #950000;
    errors++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    s = 0; m = 0; h = 0; d = 1; mo = 1; y = 0; w = 0; sub = 0; lock = 0;
    for (int i = 0; i < 8; i++) cfg[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    check_all("R1");
    rd(5'h15, rv); chk("R1", "dst enable reg", rv, 8'h00);
    rd(5'h1C, rv); chk("R1", "reverse hour reg", rv, 8'h00);
    // R7: unmapped address
    rd(5'h1D, rv); chk("R7", "unmapped 1D", rv, 8'h00);
    rd(5'h10, rv); chk("R7", "unmapped 10", rv, 8'h00);

    // R2: 50-cycle second
    mode_60hz = 1'b0;
    wr(5'h00, 8'h00);
    repeat (49) pulse();
    rd(5'h07, rv); chk("R2", "sub at 49", rv, 8'h49);
    chk("R2", "no tick yet", tick_cnt, 0);
    pulse();
    check_all("R2");
    rd(5'h00, rv); chk("R2", "seconds 50Hz", rv, 8'h01);

    // R2: 60-cycle second
    mode_60hz = 1'b1;
    wr(5'h07, 8'h33);
    rd(5'h07, rv); chk("R8", "sub after 07 write", rv, 8'h00);
    repeat (59) pulse();
    rd(5'h07, rv); chk("R2", "sub at 59", rv, 8'h59);
    pulse();
    rd(5'h00, rv); chk("R2", "seconds 60Hz", rv, 8'h02);
    chk("R2", "tick count 60Hz", tick_cnt, 2);

    // R8: write restarts the second, write beats a pulse
    repeat (25) pulse();
    wr(5'h01, 8'h10);
    rd(5'h07, rv); chk("R8", "sub after write", rv, 8'h00);
    repeat (3) pulse();
    @(negedge clk); reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = 8'h30; line_pulse = 1'b1;
    @(negedge clk); reg_we = 1'b0; line_pulse = 1'b0;
    model_write(5'h00, 8'h30);
    rd(5'h07, rv); chk("R8", "pulse lost to write", rv, 8'h00);
    check_all("R8");

    // R3 R4: end of day, day-of-week wrap
    set_time(21, 6, 15, 23, 59, 59, 6);
    one_second();
    check_all("R4");
    rd(5'h06, rv); chk("R4", "dow wrap", rv, 8'h00);
    rd(5'h03, rv); chk("R4", "date advance", rv, 8'h16);
    rd(5'h01, rv); chk("R3", "minute wrap", rv, 8'h00);

    // R5: month lengths and leap year
    set_time(24, 2, 28, 23, 59, 59, 2);
    one_second();
    rd(5'h03, rv); chk("R5", "leap feb 29", rv, 8'h29);
    set_time(23, 2, 28, 23, 59, 59, 2);
    one_second();
    rd(5'h03, rv); chk("R5", "common feb to 01", rv, 8'h01);
    rd(5'h04, rv); chk("R5", "common feb to mar", rv, 8'h03);
    set_time(10, 4, 30, 23, 59, 59, 0);
    one_second();
    check_all("R5");

    // R6: year wrap
    set_time(99, 12, 31, 23, 59, 59, 3);
    one_second();
    rd(5'h05, rv); chk("R6", "year wrap", rv, 8'h00);
    rd(5'h04, rv); chk("R6", "month wrap", rv, 8'h01);
    check_all("R6");

    // R7 R9: spring jump
    wr(5'h15, 8'h83); wr(5'h16, 8'h05); wr(5'h17, 8'h10); wr(5'h18, 8'h02);
    rd(5'h16, rv); chk("R7", "day reg readback", rv, 8'h05);
    rd(5'h15, rv); chk("R7", "enable reg readback", rv, 8'h83);
    set_time(30, 3, 10, 1, 59, 59, 0);
    one_second();
    rd(5'h02, rv); chk("R9", "spring hour", rv, 8'h03);
    check_all("R9");

    // R10: autumn step, blocked repeat, lock release
    wr(5'h19, 8'h11); wr(5'h1B, 8'h03); wr(5'h1C, 8'h02);
    set_time(30, 11, 3, 1, 59, 59, 0);
    one_second();
    rd(5'h02, rv); chk("R10", "autumn step back", rv, 8'h01);
    wr(5'h01, 8'h59); wr(5'h00, 8'h59);
    one_second();
    rd(5'h02, rv); chk("R10", "repeat hour held", rv, 8'h02);
    wr(5'h01, 8'h59); wr(5'h00, 8'h59);
    one_second();
    rd(5'h02, rv); chk("R10", "after repeat", rv, 8'h03);
    check_all("R10");

    // R11: enable clear
    wr(5'h15, 8'h03);
    set_time(30, 3, 10, 1, 59, 59, 0);
    one_second();
    rd(5'h02, rv); chk("R11", "no spring jump", rv, 8'h02);
    set_time(30, 11, 3, 1, 59, 59, 0);
    one_second();
    rd(5'h02, rv); chk("R11", "no autumn step", rv, 8'h02);

    // R3: random scenarios
    for (int it = 0; it < 40; it++) begin
      int yy, mm, dd, hh, mi, ss, en, np;
      mode_60hz = 1'($urandom % 2);
      yy = $urandom % 100; mm = 1 + $urandom % 12; dd = 1 + $urandom % days_in(mm, yy);
      if ($urandom % 3 == 0) dd = days_in(mm, yy);
      hh = $urandom % 24; mi = ($urandom % 2) ? 59 : $urandom % 60;
      ss = ($urandom % 2) ? 58 + $urandom % 2 : $urandom % 60;
      en = $urandom % 2;
      wr(5'h15, 8'(tobcd(mm) | (en << 7)));
      wr(5'h17, tobcd(dd)); wr(5'h18, tobcd((hh + 1) % 23));
      wr(5'h19, tobcd(mm)); wr(5'h1B, tobcd(dd));
      wr(5'h1C, tobcd(((hh + ($urandom % 2)) % 23) + 1));
      set_time(yy, mm, dd, hh, mi, ss, $urandom % 7);
      np = $urandom % (3 * (mode_60hz ? 60 : 50));
      repeat (np) pulse();
      check_all("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule